// File: doc/BRIEF.md
# Cascadable Four-Channel Reload Timer Bank

This block provides a bank of 16-bit up-counting timers that share one small 16-bit register port. Each channel has two words: a data word and a control word. Reading the data word returns the live count. Writing it only loads a hidden reload value. That reload value enters the counter in two cases: when the channel is switched on, and when the counter wraps past its all-ones value. As a result, software can set the period of the next cycle without disturbing the cycle that is running.

Each channel advances in one of two ways. It can count the system clock through its own divider, which divides by 1, 64, 256 or 1024. Every channel above the lowest can instead advance once for each wrap of the channel below it, which builds longer timers out of a chain. Each wrap can produce a one-clock interrupt pulse on that channel's own output line, for use by an external interrupt controller.

Top module: `reload_timer_bank`

## Requirements
- R1: After reset, every count, reload value and control field is zero, all interrupt lines are low, and every register reads zero.
- R2: Channel n's data word sits at byte address 4n and its control word at byte address 4n+2; address bit 0 is ignored. A write takes effect at the clock edge where `bus_we` is sampled high. `bus_rdata` is registered and shows, one edge after the address was presented, the register as it stood before that edge.
- R3: The control word carries the divider select in bits 1:0, chaining in bit 2, interrupt enable in bit 6 and run enable in bit 7. Bits 15:8 and 5:3 always read zero, and on channel 0 bit 2 is not stored and reads zero.
- R4: Divider code 00 advances the count on every edge, 01 every 64th, 10 every 256th and 11 every 1024th. The divider restarts when the channel is switched on, so the first advance comes a full period after the enabling edge.
- R5: While run enable is clear, the count holds its value.
- R6: A control write that changes run enable from 0 to 1 loads the count from the reload value. A control write made while run enable is already 1 does not reload.
- R7: A data write changes only the reload value; the running count is not altered by it.
- R8: When the count advances from 0xFFFF, it takes the reload value instead of wrapping to zero.
- R9: If a data write and a wrap occur in the same cycle, the count takes the newly written value.
- R10: A channel with chaining set advances once per wrap of the next-lower channel, in the same cycle, and only while its own run enable is set. Its divider select is then ignored, and its own wrap passes further up in that same cycle.
- R11: Each wrap of a channel whose interrupt enable is set gives a one-clock high pulse on that channel's `irq` bit, in the cycle after the wrap edge. With interrupt enable clear, the bit stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 4 | Per-channel wrap interrupt pulses |

## Verification
A vector table runs single channels at each divider code. Reload values are chosen to separate several faults: an off-by-one in the divider period (a count read just before and just after the 64th edge), a wrap to zero instead of a reload (reload values of 0xFFFE and 0xFFFF), and a wrong divisor (long waits at codes 10 and 11). Directed sequences then exercise the reload rules. These cover a data write while stopped, a repeated enable that must not reload, and a data write landing on the wrap edge, which tells the new reload value apart from the old one. A three-channel chain tells chaining apart from prescaled counting, because the middle channel has its divider set to 1024 yet must follow the lowest channel's wraps. The chain also shows that turning off a middle link freezes the channel above it.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

  // Divider counter width, large enough for the slowest rate (1024).
  localparam int PRESC_W = 10;

  // Control word bit positions, decoded by software.
  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_IRQ_BIT  = 6;
  localparam int CTL_CASC_BIT = 2;
  localparam int CTL_RATE_LSB = 0;

  typedef enum logic [1:0] {
    RATE_DIV1    = 2'b00,
    RATE_DIV64   = 2'b01,
    RATE_DIV256  = 2'b10,
    RATE_DIV1024 = 2'b11
  } rate_e;

  typedef struct packed {
    logic  en;
    logic  irq_en;
    rate_e rate;
  } tmr_ctrl_t;

  // Terminal count of the divider for a given rate code (period minus one).
  function automatic logic [PRESC_W-1:0] rate_terminal(input rate_e r);
    logic [PRESC_W-1:0] t;
    case (r)
      RATE_DIV1:    t = PRESC_W'(0);
      RATE_DIV64:   t = PRESC_W'(63);
      RATE_DIV256:  t = PRESC_W'(255);
      default:      t = PRESC_W'(1023);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler
  import timer_bank_pkg::*;
#(
  parameter int PW = PRESC_W
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  logic  restart,
  input  rate_e rate,
  output logic  tick
);

  logic [PW-1:0] div_q;
  logic [PW-1:0] term;

  always_comb begin
    term = PW'(rate_terminal(rate));
    // >= keeps the divider bounded when the rate is lowered mid-run
    tick = run && (div_q >= term);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= tick ? '0 : div_q + 1'b1;
    end
  end

  // R4
  divider_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (div_q == '0))
    else $error("divider not restarted on enable");

endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_bank_pkg::*;
#(
  parameter int DW       = 16,
  parameter bit HAS_CASC = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_we,
  input  logic          ctrl_we,
  input  logic [DW-1:0] wr_data,
  input  logic          casc_in,
  output logic          wrap_o,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] ctrl_rd_o,
  output logic          irq_o
);

  tmr_ctrl_t     ctrl_q;
  logic          casc_q;
  logic [DW-1:0] reload_q;
  logic [DW-1:0] cnt_q;
  logic          irq_q;

  logic          en_rise;
  logic [DW-1:0] reload_val;
  logic          ptick;
  logic          step;
  logic          wrap;

  // Chaining bit exists only on channels that have a lower neighbour.
  generate
    if (HAS_CASC) begin : g_casc
      always_ff @(posedge clk) begin
        if (rst) begin
          casc_q <= 1'b0;
        end else if (ctrl_we) begin
          casc_q <= wr_data[CTL_CASC_BIT];
        end
      end
    end else begin : g_nocasc
      assign casc_q = 1'b0;
    end
  endgenerate

  always_comb begin
    en_rise    = ctrl_we && wr_data[CTL_EN_BIT] && !ctrl_q.en;
    reload_val = data_we ? wr_data : reload_q;
    step       = ctrl_q.en && (casc_q ? casc_in : ptick);
    wrap       = step && (&cnt_q);
  end

  timer_prescaler #(.PW(PRESC_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.en && !casc_q),
    .restart (en_rise),
    .rate    (ctrl_q.rate),
    .tick    (ptick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q.en     <= wr_data[CTL_EN_BIT];
      ctrl_q.irq_en <= wr_data[CTL_IRQ_BIT];
      ctrl_q.rate   <= rate_e'(wr_data[CTL_RATE_LSB +: 2]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
    end else if (data_we) begin
      reload_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en_rise) begin
      cnt_q <= reload_q;
    end else if (wrap) begin
      cnt_q <= reload_val;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= wrap && ctrl_q.irq_en;
    end
  end

  always_comb begin
    ctrl_rd_o               = '0;
    ctrl_rd_o[CTL_EN_BIT]   = ctrl_q.en;
    ctrl_rd_o[CTL_IRQ_BIT]  = ctrl_q.irq_en;
    ctrl_rd_o[CTL_CASC_BIT] = casc_q;
    ctrl_rd_o[CTL_RATE_LSB +: 2] = ctrl_q.rate;
  end

  assign wrap_o  = wrap;
  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  // R5
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.en && !ctrl_we) |=> $stable(cnt_q))
    else $error("count moved while stopped");

  // R6
  enable_load_chk: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> (ctrl_q.en && cnt_q == $past(reload_q)))
    else $error("enable did not load reload value");

  // R7
  data_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (data_we && !step && !ctrl_we) |=> $stable(cnt_q))
    else $error("data write altered count");

  // R8
  reload_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == $past(reload_val)))
    else $error("wrap did not reload");

  // R10
  chain_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (casc_q && !casc_in && !ctrl_we) |=> $stable(cnt_q))
    else $error("chained channel moved without lower wrap");

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(wrap && ctrl_q.irq_en))
    else $error("irq without enabled wrap");

endmodule

// File: rtl/reload_timer_bank.sv
module reload_timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  logic [CH_W-1:0]   sel_ch;
  logic              sel_ctrl;
  logic              unused_addr_lsb;
  logic [DATA_W-1:0] cnt_w  [NUM_CH];
  logic [DATA_W-1:0] ctrl_w [NUM_CH];
  logic [NUM_CH-1:0] wrap_w;
  logic [NUM_CH-1:0] irq_w;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rd_q;

  assign sel_ch          = bus_addr[ADDR_W-1:2];
  assign sel_ctrl        = bus_addr[1];
  assign unused_addr_lsb = bus_addr[0];

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      logic casc_src;
      assign hit = (sel_ch == CH_W'(i));
      if (i == 0) begin : g_bottom
        assign casc_src = 1'b0;
      end else begin : g_upper
        assign casc_src = wrap_w[i-1];
      end
      timer_channel #(
        .DW       (DATA_W),
        .HAS_CASC (i != 0)
      ) u_chan (
        .clk       (clk),
        .rst       (rst),
        .data_we   (bus_we && hit && !sel_ctrl),
        .ctrl_we   (bus_we && hit && sel_ctrl),
        .wr_data   (bus_wdata),
        .casc_in   (casc_src),
        .wrap_o    (wrap_w[i]),
        .count_o   (cnt_w[i]),
        .ctrl_rd_o (ctrl_w[i]),
        .irq_o     (irq_w[i])
      );
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_ch == CH_W'(i)) begin
        rd_next = sel_ctrl ? ctrl_w[i] : cnt_w[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_next;
    end
  end

  assign bus_rdata = rd_q;
  assign irq       = irq_w;

  // R3
  ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr[1]) |-> (bus_rdata[DATA_W-1:8] == '0 && bus_rdata[5:3] == '0))
    else $error("reserved control bits read nonzero");

  // R1
  irq_clear_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0 && bus_rdata == '0))
    else $error("outputs not cleared by reset");

endmodule

// File: tb/reload_timer_bank_tb_top.sv
`timescale 1ns/1ps
module reload_timer_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  reload_timer_bank dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  rate;
    logic [15:0] reload;
    logic [15:0] wait_n;
    logic [15:0] expect_cnt;
  } vec_t;

  // Count after wait_n edges following the enabling edge:
  // reload + floor(wait_n / period), with reload on wrap.
  localparam vec_t VECS [8] = '{
    '{2'd0, 2'b00, 16'h1000, 16'd10,   16'h100A},
    '{2'd1, 2'b01, 16'h0000, 16'd63,   16'h0000},
    '{2'd1, 2'b01, 16'h0000, 16'd64,   16'h0001},
    '{2'd2, 2'b10, 16'h0005, 16'd600,  16'h0007},
    '{2'd3, 2'b11, 16'hFFF0, 16'd2100, 16'hFFF2},
    '{2'd0, 2'b00, 16'hFFFE, 16'd5,    16'hFFFF},
    '{2'd2, 2'b01, 16'h8000, 16'd200,  16'h8003},
    '{2'd3, 2'b00, 16'hFFFF, 16'd3,    16'hFFFF}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    #1;
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    @(posedge clk);
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] v2;
    int irq_seen;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;

    // R1 / R2: all words read zero after reset
    for (int a = 0; a < 16; a += 2) begin
      rd(4'(a), v);
      check($sformatf("R1 reset word at %0d", a), v, 16'h0000);
    end
    check("R1 irq after reset", {12'h0, irq}, 16'h0000);

    // R3: control layout and reserved bits
    wr(4'd6, 16'hFFFF);
    rd(4'd6, v);
    check("R3 ch1 control readback", v, 16'h00C7);
    wr(4'd2, 16'hFFFF);
    rd(4'd2, v);
    check("R3 ch0 chaining bit absent", v, 16'h00C3);
    wr(4'd6, 16'h0000);
    wr(4'd2, 16'h0000);

    // R4 / R8: vector table
    foreach (VECS[i]) begin
      logic [3:0] da;
      da = {VECS[i].ch, 2'b00};
      wr(da | 4'd2, 16'h0000);
      wr(da, VECS[i].reload);
      wr(da | 4'd2, {8'h00, 1'b1, 5'b0, VECS[i].rate});
      idle(VECS[i].wait_n);
      rd(da, v);
      check($sformatf("R4/R8 vector %0d", i), v, VECS[i].expect_cnt);
    end
    for (int c = 0; c < 4; c++) wr(4'(c * 4 + 2), 16'h0000);

    // R5: stopped channel holds
    wr(4'd0, 16'h0100);
    wr(4'd2, 16'h0080);
    idle(3);
    wr(4'd2, 16'h0000);
    idle(20);
    rd(4'd0, v);
    check("R5 hold while stopped", v, 16'h0104);

    // R7: data write while stopped leaves count
    wr(4'd0, 16'h1234);
    rd(4'd0, v);
    check("R7 data write no count change", v, 16'h0104);

    // R6: enable edge loads reload value
    wr(4'd2, 16'h0080);
    rd(4'd0, v);
    check("R6 enable loads reload", v, 16'h1234);
    // R6 / R7: re-enable while running does not reload
    wr(4'd0, 16'h0000);
    wr(4'd2, 16'h0080);
    rd(4'd0, v);
    check("R6 repeated enable no reload", v, 16'h1237);

    // R9 / R11: data write on wrap edge, irq pulse
    wr(4'd2, 16'h0000);
    wr(4'd0, 16'hFFFD);
    wr(4'd2, 16'h00C0);
    idle(2);
    wr(4'd0, 16'h4000);
    check("R11 irq pulse after wrap", {15'h0, irq[0]}, 16'h0001);
    rd(4'd0, v);
    check("R9 same-cycle write reloads new value", v, 16'h4000);
    check("R11 irq pulse one clock", {15'h0, irq[0]}, 16'h0000);

    // R11: no irq with enable bit clear, then pulses when set
    wr(4'd2, 16'h0000);
    wr(4'd0, 16'hFFFF);
    wr(4'd2, 16'h0080);
    irq_seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk);
      #1;
      if (irq[0]) irq_seen++;
    end
    check("R11 no irq when disabled", 16'(irq_seen), 16'h0000);
    wr(4'd2, 16'h00C0);
    @(posedge clk);
    #1;
    check("R11 irq on wrap 1", {15'h0, irq[0]}, 16'h0001);
    @(posedge clk);
    #1;
    check("R11 irq on wrap 2", {15'h0, irq[0]}, 16'h0001);
    wr(4'd2, 16'h0000);
    idle(1);
    check("R11 irq low after stop", {15'h0, irq[0]}, 16'h0000);

    // R10: three-channel chain
    wr(4'd4, 16'hFFFF);
    wr(4'd8, 16'h0000);
    wr(4'd10, 16'h0084);
    wr(4'd6, 16'h0087);
    wr(4'd0, 16'hFFFE);
    wr(4'd2, 16'h0080);
    idle(20);
    rd(4'd8, v);
    check("R10 chained count", v, 16'h000A);
    rd(4'd4, v);
    check("R10 middle link reloads", v, 16'hFFFF);
    wr(4'd6, 16'h0004);
    idle(10);
    rd(4'd8, v);
    rd(4'd8, v2);
    check("R10 top frozen when link stopped", v, 16'h000B);
    check("R10 top stays frozen", v2, 16'h000B);
    wr(4'd2, 16'h0000);
    wr(4'd10, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule